// File: doc/BRIEF.md
# Serial Command Bus Bridge

This block turns a stream of command bytes into accesses on an internal register bus with 16-bit addresses and 8-bit data. Bytes arrive over a valid/ready handshake from a serial receiver. Responses leave over a second valid/ready handshake towards a transmitter. The first byte of each frame carries flag bits. These flags decide whether the access is a read or a write, whether a length byte follows, and whether each byte of the transfer must first wait on a condition. That condition is checked by a separate polling unit. The bridge hands it the watched address, a mask, the expected value and the timeout limit, then waits for the unit's verdict.

Each read or write frame is answered. A read returns the data bytes that were read. Every answer then ends with a status byte that counts the bytes actually processed. When a poll times out, the rest of the transfer still runs to its end so that the byte streams stay aligned. A read sends zeros for the remaining bytes. A write swallows the remaining bytes without writing them to the bus. A separate configuration frame loads the 32-bit timeout limit. A malformed command byte locks the bridge in an error state.

Top module: `sbus_bridge`

## Requirements
- R1: Command byte bits: bit 0 = write (1) or read (0), bit 1 = length byte present, bit 2 = poll fields present. The value 0x08 is the timeout configuration command. Any other byte with a bit set in positions 7..3 drives `err` high.
- R2: Field order after the command byte: target address, then (if polling) poll address, mask and expected value, then (if sized) the length byte. Both addresses arrive high byte first.
- R3: Without a length byte, a transfer moves exactly one byte. With a length byte, it moves that many bytes.
- R4: A write issues one `bus_wr` pulse per data byte, all to the same `bus_addr`. The address does not increment. `bus_wr` and `bus_rd` are never high together.
- R5: A read issues one `bus_rd` pulse per byte. Each byte is taken from `bus_rdata` one cycle after its pulse and sent on tx in order, before the status byte.
- R6: Every read or write frame ends with one status byte. Its value is the number of bytes that were actually written or read on the bus.
- R7: When polling is enabled, each byte is preceded by a single-cycle `poll_start` with `poll_addr`/`poll_mask`/`poll_value` set. The bridge then waits for `poll_done` before touching the bus.
- R8: After a poll reports `poll_miss` in a read, no more polls or bus reads occur. Every remaining byte, including the one that missed, is sent as 0x00.
- R9: After a poll reports `poll_miss` in a write, all remaining data bytes of the frame are still accepted but none is written to the bus.
- R10: Command 0x08 is followed by four bytes that form `poll_limit`, most significant first. It sends no response. `poll_limit` is 0 after reset.
- R11: Once `err` is high, it stays high until reset. While it is high, incoming bytes are consumed with no bus access, no poll and no response.
- R12: `tx_data` and `tx_valid` stay unchanged while `tx_valid` is high and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Incoming command byte |
| rx_valid | input | 1 | rx_data holds a byte |
| rx_ready | output | 1 | Bridge accepts the byte this cycle |
| tx_data | output | 8 | Outgoing response byte |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 8 | Register bus write data |
| bus_wr | output | 1 | Write strobe, one cycle per byte |
| bus_rd | output | 1 | Read strobe, one cycle per byte |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_rd |
| poll_start | output | 1 | Start one poll of the condition |
| poll_addr | output | 16 | Address the polling unit watches |
| poll_mask | output | 8 | Bits compared by the polling unit |
| poll_value | output | 8 | Expected value of the masked bits |
| poll_done | input | 1 | Polling unit has a verdict |
| poll_miss | input | 1 | With poll_done: the poll timed out |
| poll_limit | output | 32 | Configured poll timeout, 0 = none |
| err | output | 1 | Sticky malformed-command flag |

## Verification
A handshaked rx byte is acted on at the next clock edge. A write strobe appears one cycle after the last data byte is accepted. A read byte appears on tx three cycles after its strobe: one cycle of bus latency, one capture cycle and one load cycle. The status byte follows one cycle after the last data byte leaves. The bench does not count cycles per frame. It logs every tx handshake, bus strobe and poll start at the falling edge. It waits until the expected number of tx bytes has arrived, or a fixed window has passed for silent frames, and only then compares the logs. This also holds under tx back-pressure, which only stretches those latencies.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  typedef enum logic [3:0] {
    ST_CMD, ST_ADDR, ST_PADDR, ST_MASK, ST_VAL, ST_SIZE, ST_CFG, ST_NEXT,
    ST_PWAIT, ST_XFER, ST_WDATA, ST_RREQ, ST_RCAP, ST_SEND, ST_STAT, ST_ERR
  } st_e;

  typedef struct packed {
    logic ok;
    logic cfg;
    logic wr;
    logic sized;
    logic polled;
  } cmd_t;

  localparam logic [7:0] CFG_OP = 8'h08;
endpackage

// File: rtl/sbb_cmd_decode.sv
module sbb_cmd_decode
  import sbb_pkg::*;
(
  input  logic [7:0] op,
  output cmd_t       dec
);
  always_comb begin
    dec.cfg    = (op == CFG_OP);
    dec.ok     = dec.cfg || (op[7:3] == 5'd0);
    dec.wr     = op[0];
    dec.sized  = op[1];
    dec.polled = op[2];
  end
endmodule

// File: rtl/sbb_shift_field.sv
module sbb_shift_field #(
  parameter int W = 16,
  parameter int B = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [B-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-B-1:0], din};
  end
endmodule

// File: rtl/sbb_tx_slot.sv
module sbb_tx_slot #(
  parameter int B = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [B-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [B-1:0] data,
  output logic         free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sbus_bridge.sv
module sbus_bridge
  import sbb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TMO_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              poll_start,
  output logic [ADDR_W-1:0] poll_addr,
  output logic [DATA_W-1:0] poll_mask,
  output logic [DATA_W-1:0] poll_value,
  input  logic              poll_done,
  input  logic              poll_miss,
  output logic [TMO_W-1:0]  poll_limit,
  output logic              err
);
  localparam int ADDR_BYTES = ADDR_W / DATA_W;
  localparam int TMO_BYTES  = TMO_W / DATA_W;
  localparam int MAXB       = (TMO_BYTES > ADDR_BYTES) ? TMO_BYTES : ADDR_BYTES;
  localparam int FCNT_W     = $clog2(MAXB) + 1;
  localparam logic [FCNT_W-1:0] ALAST = FCNT_W'(ADDR_BYTES - 1);
  localparam logic [FCNT_W-1:0] TLAST = FCNT_W'(TMO_BYTES - 1);

  st_e               st;
  cmd_t              dec;
  logic [FCNT_W-1:0] fcnt;
  logic              f_wr, f_sized, f_polled, tmo_hit;
  logic [DATA_W-1:0] remain, done_cnt, rbuf;
  logic              take, tx_free, tx_load;
  logic [DATA_W-1:0] tx_din;

  always_comb begin
    case (st)
      ST_CMD, ST_ADDR, ST_PADDR, ST_MASK, ST_VAL, ST_SIZE,
      ST_CFG, ST_WDATA, ST_ERR: rx_ready = 1'b1;
      default:                  rx_ready = 1'b0;
    endcase
  end
  assign take = rx_valid && rx_ready;
  assign err  = (st == ST_ERR);

  sbb_cmd_decode u_dec (.op(rx_data), .dec(dec));

  sbb_shift_field #(.W(ADDR_W), .B(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .en(take && st == ST_ADDR), .din(rx_data), .q(bus_addr));
  sbb_shift_field #(.W(ADDR_W), .B(DATA_W)) u_paddr (
    .clk(clk), .rst(rst), .en(take && st == ST_PADDR), .din(rx_data), .q(poll_addr));
  sbb_shift_field #(.W(TMO_W), .B(DATA_W)) u_limit (
    .clk(clk), .rst(rst), .en(take && st == ST_CFG), .din(rx_data), .q(poll_limit));

  always_comb begin
    tx_load = 1'b0;
    tx_din  = rbuf;
    if (st == ST_SEND && tx_free) tx_load = 1'b1;
    if (st == ST_STAT && tx_free) begin
      tx_load = 1'b1;
      tx_din  = done_cnt;
    end
  end

  sbb_tx_slot #(.B(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .din(tx_din), .ready(tx_ready),
    .valid(tx_valid), .data(tx_data), .free(tx_free));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_CMD;   fcnt <= '0;
      f_wr <= 1'b0;   f_sized <= 1'b0;  f_polled <= 1'b0; tmo_hit <= 1'b0;
      remain <= '0;   done_cnt <= '0;   rbuf <= '0;
      poll_mask <= '0; poll_value <= '0; bus_wdata <= '0;
      bus_wr <= 1'b0; bus_rd <= 1'b0;   poll_start <= 1'b0;
    end else begin
      bus_wr     <= 1'b0;
      bus_rd     <= 1'b0;
      poll_start <= 1'b0;
      case (st)
        ST_CMD: if (take) begin
          fcnt <= '0;
          if (dec.cfg)      st <= ST_CFG;
          else if (!dec.ok) st <= ST_ERR;
          else begin
            f_wr <= dec.wr; f_sized <= dec.sized; f_polled <= dec.polled;
            remain <= DATA_W'(1); done_cnt <= '0; tmo_hit <= 1'b0;
            st <= ST_ADDR;
          end
        end
        ST_ADDR: if (take) begin
          if (fcnt == ALAST) begin
            fcnt <= '0;
            st   <= f_polled ? ST_PADDR : (f_sized ? ST_SIZE : ST_NEXT);
          end else fcnt <= fcnt + 1'b1;
        end
        ST_PADDR: if (take) begin
          if (fcnt == ALAST) begin
            fcnt <= '0;
            st   <= ST_MASK;
          end else fcnt <= fcnt + 1'b1;
        end
        ST_MASK: if (take) begin
          poll_mask <= rx_data;
          st        <= ST_VAL;
        end
        ST_VAL: if (take) begin
          poll_value <= rx_data;
          st         <= f_sized ? ST_SIZE : ST_NEXT;
        end
        ST_SIZE: if (take) begin
          remain <= rx_data;
          st     <= ST_NEXT;
        end
        ST_CFG: if (take) begin
          if (fcnt == TLAST) begin
            fcnt <= '0;
            st   <= ST_CMD;
          end else fcnt <= fcnt + 1'b1;
        end
        ST_NEXT: begin
          if (remain == '0) st <= ST_STAT;
          else if (f_polled && !tmo_hit) begin
            poll_start <= 1'b1;
            st         <= ST_PWAIT;
          end else st <= ST_XFER;
        end
        ST_PWAIT: if (poll_done) begin
          tmo_hit <= poll_miss;
          st      <= ST_XFER;
        end
        ST_XFER: begin
          if (f_wr) st <= ST_WDATA;
          else if (tmo_hit) begin
            rbuf <= '0;
            st   <= ST_SEND;
          end else begin
            bus_rd <= 1'b1;
            st     <= ST_RREQ;
          end
        end
        ST_WDATA: if (take) begin
          if (!tmo_hit) begin
            bus_wr    <= 1'b1;
            bus_wdata <= rx_data;
            done_cnt  <= done_cnt + 1'b1;
          end
          remain <= remain - 1'b1;
          st     <= ST_NEXT;
        end
        ST_RREQ: st <= ST_RCAP;
        ST_RCAP: begin
          rbuf     <= bus_rdata;
          done_cnt <= done_cnt + 1'b1;
          st       <= ST_SEND;
        end
        ST_SEND: if (tx_free) begin
          remain <= remain - 1'b1;
          st     <= ST_NEXT;
        end
        ST_STAT: if (tx_free) st <= ST_CMD;
        ST_ERR:  st <= ST_ERR;
        default: st <= ST_ERR;
      endcase
    end
  end
endmodule

// File: rtl/sbus_bridge_chk.sv
module sbus_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       poll_start,
  input logic       err
);
  // R4
  no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R11
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!bus_wr && !bus_rd && !poll_start));

  // R7
  poll_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    poll_start |=> !poll_start);
endmodule

bind sbus_bridge sbus_bridge_chk chk_i (.*);

// File: tb/sbus_bridge_tb.sv
`timescale 1ns/1ps
module sbus_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_rdata = 8'h00;
  logic        poll_start;
  logic [15:0] poll_addr;
  logic [7:0]  poll_mask, poll_value;
  logic        poll_done = 1'b0;
  logic        poll_miss = 1'b0;
  logic [31:0] poll_limit;
  logic        err;

  always #2 clk = ~clk;

  sbus_bridge dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 1'b0, bp = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] txb [64];
  int tx_n = 0, wr_n = 0, rd_n = 0;
  logic [15:0] last_waddr = '0, last_paddr = '0;
  logic [7:0]  last_wdata = '0, last_pmask = '0, last_pval = '0;
  int poll_seen = 0, poll_budget = 0, pdly = 0;

  always @(posedge clk) begin
    if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
    if (bus_rd) bus_rdata <= mem[bus_addr[7:0]];
    tx_ready <= bp ? ~tx_ready : 1'b1;
    poll_done <= 1'b0;
    if (poll_start) begin
      pdly       <= 3;
      poll_miss  <= (poll_seen >= poll_budget);
      poll_seen  <= poll_seen + 1;
      last_paddr <= poll_addr;
      last_pmask <= poll_mask;
      last_pval  <= poll_value;
    end else if (pdly > 0) begin
      pdly <= pdly - 1;
      if (pdly == 1) poll_done <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      txb[tx_n[5:0]] = tx_data;
      tx_n = tx_n + 1;
    end
    if (bus_wr) begin
      wr_n = wr_n + 1;
      last_waddr = bus_addr;
      last_wdata = bus_wdata;
    end
    if (bus_rd) rd_n = rd_n + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_tx(input int n);
    for (int i = 0; i < 2000 && tx_n < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 err after reset", err, 0);
    check("R5 tx idle after reset", tx_valid, 0);
    check("R4 no strobe after reset", bus_wr | bus_rd, 0);
    check("R10 limit default", poll_limit, 0);
  endtask

  task automatic t_wr_single();
    int b = tx_n, w = wr_n;
    send(8'h01); send(8'h12); send(8'h34); send(8'hA5);
    wait_tx(b + 1);
    check("R2 write address hi first", last_waddr, 16'h1234);
    check("R4 write data", last_wdata, 8'hA5);
    check("R3 default length one", wr_n - w, 1);
    check("R6 status single write", txb[b[5:0]], 8'h01);
  endtask

  task automatic t_wr_multi();
    int b = tx_n, w = wr_n;
    send(8'h03); send(8'h00); send(8'h42); send(8'h03);
    send(8'h11); send(8'h22); send(8'h33);
    wait_tx(b + 1);
    check("R3 sized write count", wr_n - w, 3);
    check("R4 same address", last_waddr, 16'h0042);
    check("R4 last data", last_wdata, 8'h33);
    check("R6 status sized write", txb[b[5:0]], 8'h03);
  endtask

  task automatic t_rd();
    int b = tx_n, r = rd_n;
    bp = 1'b1;
    send(8'h02); send(8'h00); send(8'h42); send(8'h02);
    wait_tx(b + 3);
    check("R5 read byte 0", txb[b[5:0]], 8'h33);
    check("R5 read byte 1", txb[6'(b + 1)], 8'h33);
    check("R6 read status", txb[6'(b + 2)], 8'h02);
    check("R5 read strobes", rd_n - r, 2);
    bp = 1'b0;
    b = tx_n;
    send(8'h00); send(8'h12); send(8'h34);
    wait_tx(b + 2);
    check("R3 single read data", txb[b[5:0]], 8'hA5);
    check("R3 single read status", txb[6'(b + 1)], 8'h01);
  endtask

  task automatic t_poll_wr();
    int b = tx_n, w = wr_n, p = poll_seen;
    poll_budget = poll_seen + 10;
    send(8'h07); send(8'h00); send(8'h10); send(8'hBE); send(8'hEF);
    send(8'hF0); send(8'h50); send(8'h02); send(8'h01); send(8'h02);
    wait_tx(b + 1);
    check("R7 one poll per byte", poll_seen - p, 2);
    check("R2 poll address", last_paddr, 16'hBEEF);
    check("R2 poll mask", last_pmask, 8'hF0);
    check("R2 poll value", last_pval, 8'h50);
    check("R7 polled writes", wr_n - w, 2);
    check("R6 polled write status", txb[b[5:0]], 8'h02);
  endtask

  task automatic t_poll_rd_tmo();
    int b = tx_n, r = rd_n, p = poll_seen;
    poll_budget = poll_seen + 1;
    send(8'h06); send(8'h00); send(8'h42); send(8'h01); send(8'h00);
    send(8'h01); send(8'h01); send(8'h03);
    wait_tx(b + 4);
    check("R8 first byte real", txb[b[5:0]], 8'h33);
    check("R8 pad byte 1", txb[6'(b + 1)], 8'h00);
    check("R8 pad byte 2", txb[6'(b + 2)], 8'h00);
    check("R8 short status", txb[6'(b + 3)], 8'h01);
    check("R8 polls stop", poll_seen - p, 2);
    check("R8 reads stop", rd_n - r, 1);
  endtask

  task automatic t_poll_wr_tmo();
    int b = tx_n, w = wr_n;
    poll_budget = poll_seen + 1;
    send(8'h07); send(8'h00); send(8'h20); send(8'h01); send(8'h00);
    send(8'h01); send(8'h01); send(8'h03);
    send(8'h07); send(8'h08); send(8'h09);
    wait_tx(b + 1);
    check("R9 only first written", wr_n - w, 1);
    check("R9 short status", txb[b[5:0]], 8'h01);
    b = tx_n;
    send(8'h00); send(8'h00); send(8'h20);
    wait_tx(b + 2);
    check("R9 discarded bytes unwritten", txb[b[5:0]], 8'h07);
    check("R9 stream aligned", txb[6'(b + 1)], 8'h01);
  endtask

  task automatic t_cfg();
    int b = tx_n;
    send(8'h08); send(8'h12); send(8'h34); send(8'h56); send(8'h78);
    repeat (20) @(negedge clk);
    check("R10 limit msb first", poll_limit, 32'h12345678);
    check("R10 no response", tx_n - b, 0);
  endtask

  task automatic t_err();
    int b = tx_n, w = wr_n;
    send(8'h10);
    repeat (5) @(negedge clk);
    check("R1 invalid command flags err", err, 1);
    send(8'h01); send(8'h00); send(8'h20); send(8'hFF);
    repeat (20) @(negedge clk);
    check("R11 err sticky", err, 1);
    check("R11 no response in err", tx_n - b, 0);
    check("R11 no write in err", wr_n - w, 0);
    do_reset();
    check("R11 reset clears err", err, 0);
    check("R10 limit cleared by reset", poll_limit, 0);
    b = tx_n;
    send(8'h00); send(8'h00); send(8'h20);
    wait_tx(b + 2);
    check("R11 works after reset", txb[b[5:0]], 8'h07);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_wr_single();
    t_wr_multi();
    t_rd();
    t_poll_wr();
    t_poll_rd_tmo();
    t_poll_wr_tmo();
    t_cfg();
    t_err();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule